// File: doc/BRIEF.md
# Display Control Register Bank with Set/Clear Aliases

This block is the software-visible register bank of a display controller. It holds the main control word, an auxiliary control word and a pair of frame-start address registers. Each register occupies a 16-byte slot. Within the slot, one alias overwrites the register, one alias ORs in the written bits, and one alias clears the written bits. Software can therefore flip single control bits without a read-modify-write sequence.

The frame-start address is double-buffered. Software may write the pending address at any time. The block copies it into the active address only when the frame-boundary strobe pulses. The active address is readable and also drives the scanout logic. The run bit clears itself once scanning has been switched off and the pixel FIFO reports empty. Writing the soft-reset bit returns the whole bank to zero.

The bus is word-addressed. Word address = byte offset / 4. Word-address bits [1:0] select the alias and the upper bits select the register slot. Reads return data one cycle after the read strobe, with a valid flag.

Top module: `dcr_regbank`

## Requirements
- R1: After reset every register reads zero, and `ctrl_o` and `scan_addr_o` are zero.
- R2: A write at slot offset +0 loads the whole word. A read at any of the four word offsets of a slot (+0, +4, +8, +C) returns the register's value one cycle after `bus_rd`, with `bus_rvalid` high for exactly that cycle.
- R3: A write at slot offset +4 ORs the written bits into the register and leaves all other bits unchanged.
- R4: A write at slot offset +8 clears the written bits and leaves all other bits unchanged.
- R5: The register slots are at these byte offsets:
  - control word at 0x00;
  - auxiliary word at 0x10;
  - pending address at 0x20;
  - active address at 0x30.

  Control bits are: 31 soft reset, 30 clock gate, 19 count bypass, 17 dotclock enable, 5 bus master, 0 run. Bits 11:10 hold the bus-width code and bits 9:8 hold the word-length code. Bit 21 of the auxiliary word is the FIFO-clear bit. `ctrl_o` and `aux_o` present the stored words bit for bit.
- R6: A write to the pending address leaves `scan_addr_o` and the active-address register unchanged until `frame_sync` is high at a clock edge. On that edge the pending value is copied.
- R7: If the pending address is written several times between two frame strobes, the last value written is the one copied.
- R8: The active-address register is read-only. Writes to its slot have no effect.
- R9: While run is 1 and dotclock is 0, run stays 1 as long as `fifo_empty` is low. At the first clock edge with `fifo_empty` high, run clears without any write. While dotclock is 1, run never clears by itself.
- R10: A write whose result would set control bit 31 clears every register, including run, the pending address and the active address. Bit 31 then reads 0.
- R11: The low `ALIGN_BITS` bits (default 2) of the pending address are always zero, whatever is written.
- R12: When a pending-address write and `frame_sync` fall on the same edge, the active address takes the value held before that write.
- R13: A write at slot offset +C is ignored, and reads of unmapped slots return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | WADDR_W | Word address: [1:0] alias, upper bits slot |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after `bus_rd` |
| bus_rvalid | output | 1 | Read data valid |
| frame_sync | input | 1 | Frame-boundary strobe |
| fifo_empty | input | 1 | Pixel FIFO has drained |
| ctrl_o | output | DATA_W | Control word |
| aux_o | output | DATA_W | Auxiliary control word |
| scan_addr_o | output | DATA_W | Active frame-start address |

## Verification
The alias decode is tried with overlapping bit patterns through the overwrite, OR and clear offsets on the same word. Comparing read-back before and after each write shows whether untouched bits survive and whether the alias reads match the base read.

The pending/active pair is driven three ways:
- a single write followed by a strobe;
- two writes inside one frame;
- a write landing on the same edge as the strobe.

Together these show copy-only-at-boundary, last-value-wins and old-value-on-collision.

The run bit is watched with the FIFO held busy and then released. This separates a premature clear from a missing self-clear. A final soft reset shows whether every register, including the active address, returns to zero.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

   // alias selected by word-address bits [1:0]
   typedef enum logic [1:0] {
      ALIAS_LOAD = 2'd0,
      ALIAS_OR   = 2'd1,
      ALIAS_AND  = 2'd2,
      ALIAS_NONE = 2'd3
   } alias_op_e;

   // register slot numbers
   localparam int SLOT_CTRL = 0;
   localparam int SLOT_AUX  = 1;
   localparam int SLOT_PEND = 2;
   localparam int SLOT_ACT  = 3;

   // control word bit positions
   localparam int CB_SRST   = 31;
   localparam int CB_CGATE  = 30;
   localparam int CB_BYPASS = 19;
   localparam int CB_DOTCLK = 17;
   localparam int CB_MASTER = 5;
   localparam int CB_RUN    = 0;

   // auxiliary word bit positions
   localparam int AB_FIFOCLR = 21;

endpackage

// File: rtl/dcr_alias_decode.sv
module dcr_alias_decode
   import dcr_pkg::*;
#(
   parameter int WADDR_W = 6,
   localparam int SLOT_W = WADDR_W - 2
)(
   input  logic [WADDR_W-1:0] addr,
   output logic [SLOT_W-1:0]  slot,
   output alias_op_e          op
);

   assign slot = addr[WADDR_W-1:2];
   assign op   = alias_op_e'(addr[1:0]);

endmodule

// File: rtl/dcr_setclr_reg.sv
module dcr_setclr_reg
   import dcr_pkg::*;
#(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sw_en,
   input  alias_op_e    op,
   input  logic [W-1:0] wdata,
   input  logic         soft_clr,
   input  logic [W-1:0] hw_clr,
   output logic [W-1:0] q
);

   logic [W-1:0] sw_val;
   logic [W-1:0] nxt;

   always_comb begin
      case (op)
         ALIAS_LOAD: sw_val = wdata;
         ALIAS_OR:   sw_val = q | wdata;
         ALIAS_AND:  sw_val = q & ~wdata;
         default:    sw_val = q;
      endcase
   end

   always_comb begin
      if (soft_clr)
         nxt = '0;
      else if (sw_en)
         nxt = sw_val;
      else
         nxt = q & ~hw_clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else
         q <= nxt;
   end

endmodule

// File: rtl/dcr_frame_shadow.sv
module dcr_frame_shadow
   import dcr_pkg::*;
#(
   parameter int W          = 32,
   parameter int ALIGN_BITS = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pend_we,
   input  alias_op_e    op,
   input  logic [W-1:0] wdata,
   input  logic         soft_clr,
   input  logic         frame_sync,
   output logic [W-1:0] pend_q,
   output logic [W-1:0] act_q
);

   logic [W-1:0] wdata_m;

   generate
      if (ALIGN_BITS > 0) begin : g_align
         assign wdata_m = {wdata[W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end else begin : g_noalign
         assign wdata_m = wdata;
      end
   endgenerate

   dcr_setclr_reg #(.W(W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_en    (pend_we),
      .op       (op),
      .wdata    (wdata_m),
      .soft_clr (soft_clr),
      .hw_clr   ('0),
      .q        (pend_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_q <= '0;
      else if (soft_clr)
         act_q <= '0;
      else if (frame_sync)
         act_q <= pend_q;
   end

endmodule

// File: rtl/dcr_regbank.sv
module dcr_regbank
   import dcr_pkg::*;
#(
   parameter int WADDR_W    = 6,
   parameter int DATA_W     = 32,
   parameter int ALIGN_BITS = 2,
   localparam int SLOT_W    = WADDR_W - 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WADDR_W-1:0] bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               bus_rvalid,
   input  logic               frame_sync,
   input  logic               fifo_empty,
   output logic [DATA_W-1:0]  ctrl_o,
   output logic [DATA_W-1:0]  aux_o,
   output logic [DATA_W-1:0]  scan_addr_o
);

   generate
      if (WADDR_W < 4) begin : g_bad_addr
         $error("WADDR_W must leave room for four register slots");
      end
      if (DATA_W < 32) begin : g_bad_data
         $error("DATA_W must hold control bit 31");
      end
      if (ALIGN_BITS >= DATA_W) begin : g_bad_align
         $error("ALIGN_BITS must be below DATA_W");
      end
   endgenerate

   logic [SLOT_W-1:0] slot;
   alias_op_e         op;
   logic              wr_ok;
   logic              ctrl_we;
   logic              aux_we;
   logic              next_we;
   logic              srst_hit;
   logic [DATA_W-1:0] ctrl_hw_clr;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] aux_q;
   logic [DATA_W-1:0] next_q;
   logic [DATA_W-1:0] cur_q;

   dcr_alias_decode #(.WADDR_W(WADDR_W)) u_dec (
      .addr (bus_addr),
      .slot (slot),
      .op   (op)
   );

   assign wr_ok   = bus_wr && (op != ALIAS_NONE);
   assign ctrl_we = wr_ok && (slot == SLOT_W'(SLOT_CTRL));
   assign aux_we  = wr_ok && (slot == SLOT_W'(SLOT_AUX));
   assign next_we = wr_ok && (slot == SLOT_W'(SLOT_PEND));

   // control bit 31 can only end up set via load or OR with bit 31 written
   assign srst_hit = ctrl_we && (op != ALIAS_AND) && bus_wdata[CB_SRST];

   always_comb begin
      ctrl_hw_clr = '0;
      ctrl_hw_clr[CB_RUN] = ctrl_q[CB_RUN] && !ctrl_q[CB_DOTCLK] && fifo_empty;
   end

   dcr_setclr_reg #(.W(DATA_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_en    (ctrl_we),
      .op       (op),
      .wdata    (bus_wdata),
      .soft_clr (srst_hit),
      .hw_clr   (ctrl_hw_clr),
      .q        (ctrl_q)
   );

   dcr_setclr_reg #(.W(DATA_W)) u_aux (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_en    (aux_we),
      .op       (op),
      .wdata    (bus_wdata),
      .soft_clr (srst_hit),
      .hw_clr   ('0),
      .q        (aux_q)
   );

   dcr_frame_shadow #(.W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_we    (next_we),
      .op         (op),
      .wdata      (bus_wdata),
      .soft_clr   (srst_hit),
      .frame_sync (frame_sync),
      .pend_q     (next_q),
      .act_q      (cur_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_rd;
         if (bus_rd) begin
            if (slot == SLOT_W'(SLOT_CTRL))
               bus_rdata <= ctrl_q;
            else if (slot == SLOT_W'(SLOT_AUX))
               bus_rdata <= aux_q;
            else if (slot == SLOT_W'(SLOT_PEND))
               bus_rdata <= next_q;
            else if (slot == SLOT_W'(SLOT_ACT))
               bus_rdata <= cur_q;
            else
               bus_rdata <= '0;
         end
      end
   end

   assign ctrl_o      = ctrl_q;
   assign aux_o       = aux_q;
   assign scan_addr_o = cur_q;

endmodule

// File: rtl/dcr_regbank_chk.sv
module dcr_regbank_chk #(
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_rvalid,
   input logic              frame_sync,
   input logic              fifo_empty,
   input logic [DATA_W-1:0] ctrl_o,
   input logic [DATA_W-1:0] scan_addr_o,
   input logic [DATA_W-1:0] next_q,
   input logic              ctrl_we,
   input logic              srst
);

   // R2
   rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);

   // R2
   rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_rvalid);

   // R6
   scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_sync && !srst) |=> $stable(scan_addr_o));

   // R6
   scan_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_sync && !srst) |=> (scan_addr_o == $past(next_q)));

   // R9
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o[0] && !ctrl_we && !(fifo_empty && !ctrl_o[17])) |=> ctrl_o[0]);

   // R9
   run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o[0] && !ctrl_o[17] && fifo_empty && !ctrl_we) |=> !ctrl_o[0]);

   // R10
   srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (ctrl_o == '0 && scan_addr_o == '0));

endmodule

bind dcr_regbank dcr_regbank_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_rd      (bus_rd),
   .bus_rvalid  (bus_rvalid),
   .frame_sync  (frame_sync),
   .fifo_empty  (fifo_empty),
   .ctrl_o      (ctrl_o),
   .scan_addr_o (scan_addr_o),
   .next_q      (next_q),
   .ctrl_we     (ctrl_we),
   .srst        (srst_hit)
);

// File: tb/dcr_regbank_test.sv
module dcr_regbank_test;

   localparam int WADDR_W = 6;
   localparam int DW      = 32;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [WADDR_W-1:0] bus_addr = '0;
   logic               bus_wr = 1'b0;
   logic               bus_rd = 1'b0;
   logic [DW-1:0]      bus_wdata = '0;
   logic [DW-1:0]      bus_rdata;
   logic               bus_rvalid;
   logic               frame_sync = 1'b0;
   logic               fifo_empty = 1'b0;
   logic [DW-1:0]      ctrl_o;
   logic [DW-1:0]      aux_o;
   logic [DW-1:0]      scan_addr_o;

   int checks = 0;
   int fails  = 0;

   // model of the register contents, built from the requirements
   logic [DW-1:0] m_ctrl = '0;
   logic [DW-1:0] m_aux  = '0;
   logic [DW-1:0] m_next = '0;
   logic [DW-1:0] m_cur  = '0;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   always #10 clk = ~clk;

   dcr_regbank #(.WADDR_W(WADDR_W), .DATA_W(DW), .ALIGN_BITS(2)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_rd      (bus_rd),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .bus_rvalid  (bus_rvalid),
      .frame_sync  (frame_sync),
      .fifo_empty  (fifo_empty),
      .ctrl_o      (ctrl_o),
      .aux_o       (aux_o),
      .scan_addr_o (scan_addr_o)
   );

   function automatic logic [DW-1:0] apply_alias(input logic [1:0] op,
                                                input logic [DW-1:0] old,
                                                input logic [DW-1:0] wd);
      case (op)
         2'd0:    return wd;
         2'd1:    return old | wd;
         2'd2:    return old & ~wd;
         default: return old;
      endcase
   endfunction

   task automatic model_write(input logic [7:0] boff, input logic [DW-1:0] wd);
      logic [1:0]    op;
      logic [DW-1:0] nv;
      op = boff[3:2];
      if (op == 2'd3) return;
      case (boff[7:4])
         4'd0: begin
            nv = apply_alias(op, m_ctrl, wd);
            if (nv[31]) begin
               m_ctrl = '0; m_aux = '0; m_next = '0; m_cur = '0;
            end else begin
               m_ctrl = nv;
            end
         end
         4'd1: m_aux = apply_alias(op, m_aux, wd);
         4'd2: m_next = apply_alias(op, m_next, wd) & ~32'h3;
         default: ;
      endcase
   endtask

   task automatic check(input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // byte offset in, word address on the bus
   task automatic bus_write(input logic [7:0] boff, input logic [DW-1:0] wd);
      @(negedge clk);
      bus_addr  = boff[WADDR_W+1:2];
      bus_wdata = wd;
      bus_wr    = 1'b1;
      model_write(boff, wd);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] boff, input logic [DW-1:0] exp,
                           input string req);
      @(negedge clk);
      bus_addr = boff[WADDR_W+1:2];
      bus_rd   = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic sync_pulse();
      @(negedge clk);
      frame_sync = 1'b1;
      m_cur = m_next;
      @(negedge clk);
      frame_sync = 1'b0;
   endtask

   // monitor: pops expected read data as the design returns it
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R2: unexpected read data %h expected none", bus_rdata);
         end else begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(200000 * 20);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 ctrl_o", ctrl_o, '0);
      check("R1 scan_addr_o", scan_addr_o, '0);
      for (int s = 0; s < 4; s++) bus_read(8'(s * 16), '0, "R1 reset read");

      // R2 / R5 full load, field positions, all alias reads
      bus_write(8'h00, 32'h0002_0D21);
      for (int a = 0; a < 4; a++) bus_read(8'(a * 4), m_ctrl, "R2 alias read");
      @(negedge clk);
      check("R5 bus width field", DW'(ctrl_o[11:10]), 32'd3);
      check("R5 word length field", DW'(ctrl_o[9:8]), 32'd1);
      check("R5 dotclock bit", DW'(ctrl_o[17]), 32'd1);
      check("R5 master bit", DW'(ctrl_o[5]), 32'd1);

      // R3 OR alias
      bus_write(8'h04, 32'h0008_0000);
      bus_read(8'h00, m_ctrl, "R3 or alias");
      bus_write(8'h10, 32'h0000_00F0);
      bus_write(8'h14, 32'h0020_0000);
      bus_read(8'h10, m_aux, "R3 aux fifo clear bit");
      @(negedge clk);
      check("R5 aux fifo clear bit", aux_o, 32'h0020_00F0);

      // R4 clear alias
      bus_write(8'h08, 32'h0000_0020);
      bus_read(8'h00, m_ctrl, "R4 clear alias");
      bus_write(8'h18, 32'h0000_0030);
      bus_read(8'h1C, m_aux, "R4 aux clear");

      // R6 shadowed address
      bus_write(8'h20, 32'h8000_1000);
      bus_read(8'h30, '0, "R6 active unchanged before sync");
      check("R6 scan before sync", scan_addr_o, '0);
      sync_pulse();
      @(negedge clk);
      check("R6 scan after sync", scan_addr_o, 32'h8000_1000);
      bus_read(8'h30, m_cur, "R6 active readback");

      // R7 last write in a frame wins
      bus_write(8'h20, 32'h1111_2220);
      bus_write(8'h20, 32'h3333_4440);
      sync_pulse();
      @(negedge clk);
      check("R7 last write copied", scan_addr_o, 32'h3333_4440);

      // R8 active register read-only
      bus_write(8'h30, 32'hDEAD_BEE0);
      bus_read(8'h30, 32'h3333_4440, "R8 active write ignored");

      // R11 alignment
      bus_write(8'h20, 32'h0000_0103);
      bus_read(8'h20, 32'h0000_0100, "R11 low bits zero");

      // R12 collision of pending write and strobe
      @(negedge clk);
      bus_addr   = 6'(8'h20 >> 2);
      bus_wdata  = 32'h0000_5550;
      bus_wr     = 1'b1;
      frame_sync = 1'b1;
      m_cur = m_next;
      model_write(8'h20, 32'h0000_5550);
      @(negedge clk);
      bus_wr = 1'b0;
      frame_sync = 1'b0;
      check("R12 old pending copied", scan_addr_o, 32'h0000_0100);
      bus_read(8'h20, 32'h0000_5550, "R12 pending holds new");

      // R9 run drains
      bus_write(8'h08, 32'h0002_0000);
      repeat (4) @(negedge clk);
      check("R9 run held while fifo busy", DW'(ctrl_o[0]), 32'd1);
      @(negedge clk);
      fifo_empty = 1'b1;
      m_ctrl[0] = 1'b0;
      @(negedge clk);
      check("R9 run self cleared", DW'(ctrl_o[0]), 32'd0);
      fifo_empty = 1'b0;
      bus_read(8'h00, m_ctrl, "R9 ctrl after drain");

      // R13 reserved alias and unmapped slot
      bus_write(8'h1C, 32'hFFFF_FFFF);
      bus_read(8'h10, m_aux, "R13 +C write ignored");
      bus_read(8'h40, '0, "R13 unmapped read");

      // R10 soft reset through OR alias
      bus_write(8'h04, 32'h4000_0001);
      bus_write(8'h04, 32'h8000_0000);
      for (int s = 0; s < 4; s++) bus_read(8'(s * 16), '0, "R10 soft reset read");
      check("R10 scan cleared", scan_addr_o, '0);
      check("R10 ctrl cleared", ctrl_o, '0);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++;
         fails++;
         $display("FAIL R2: actual %0d reads missing expected 0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule